// File: doc/BRIEF.md
# PC-Indexed Stride Prefetch Engine

This block sits beside a cache and watches the accesses it serves. For each load instruction address (PC) it learns the distance in bytes between consecutive accesses. Once the same distance has been seen often enough, it produces prefetch block addresses that run ahead of the access stream. Training state lives in a small set-associative table that is indexed and tagged by the PC. The stride is measured on full byte addresses, so strides that are not a multiple of the line size are still learned exactly. A learned stride survives one stray access and is dropped only after two mismatches in a row.

Instruction fetches carry no PC worth training on. For these the engine does not touch the table and simply requests the next few sequential blocks. Write-invalidate requests are filtered at the input and have no effect. Configuration inputs can limit the engine to misses only or to data accesses only. Another configuration input makes each prefetch carry the PC of the access that caused it, so a lower-level prefetcher can train on it.

Generated addresses are block-aligned. They enter a small FIFO in generation order, and a consumer drains the FIFO with a valid/ready handshake. An address already waiting in the FIFO is not added a second time. When the FIFO is full, new addresses are discarded and training carries on.

Top module: `stride_prefetcher`

## Requirements
- R1: During and after reset `pf_valid` is 0 and the table holds no entries.
- R2: Strides are measured on unmasked byte addresses. With a 48-byte stride and 64-byte blocks, a confident entry prefetches the aligned blocks of `addr + k*48` for k = 1..DEGREE, where addr is the access just seen.
- R3: A new entry starts with stride 0 and confidence 0. A 2-bit counter rises on every matching stride. Prefetches are issued only on a matching access whose updated confidence is 2 or more, so the fourth access of a steady stream is the first to prefetch.
- R4: One mismatching stride keeps both the stride and the confidence, and no prefetch is issued on it. A second mismatch in a row clears confidence to 0 and adopts the newest stride. A mismatch while confidence is 0 adopts the new stride at once.
- R5: An instruction access (`acc_instr`=1) never trains the table. It queues the NEXT_N blocks that follow its own block.
- R6: With `cfg_miss_only`=1, accesses with `acc_miss`=0 are ignored. With `cfg_data_only`=1, instruction accesses are ignored. An ignored access neither trains nor prefetches.
- R7: An access of kind 2'b10 (write-invalidate) neither trains nor prefetches. Kinds 2'b00, 2'b01 and 2'b11 are treated normally.
- R8: Prefetch addresses leave in generation order. `pf_addr` and `pf_pc` hold steady while `pf_valid`=1 and `pf_ready`=0.
- R9: A block address equal to one already in the FIFO, or to an earlier one generated in the same cycle, is dropped.
- R10: When the FIFO holds QDEPTH entries, further addresses are dropped and training continues.
- R11: `pf_pc` equals the PC of the triggering access when `cfg_tag_pc`=1, and equals 0 otherwise.
- R12: The set index is PC bits [PC_SHIFT +: log2(SETS)]. A table miss allocates the way chosen by a per-set round-robin pointer, which evicts the entry allocated WAYS allocations earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle pulse marking an observed access |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_pc | input | PC_W | Instruction address of the access |
| acc_miss | input | 1 | Access missed in the cache |
| acc_instr | input | 1 | Access is an instruction fetch |
| acc_kind | input | 2 | Request kind; 2'b10 is write-invalidate |
| cfg_miss_only | input | 1 | Use misses only |
| cfg_data_only | input | 1 | Use data accesses only |
| cfg_tag_pc | input | 1 | Attach the triggering PC to prefetches |
| pf_valid | output | 1 | FIFO head holds a prefetch |
| pf_ready | input | 1 | Consumer takes the head this cycle |
| pf_addr | output | ADDR_W | Block-aligned prefetch address |
| pf_pc | output | PC_W | Triggering PC or 0 |

## Verification
The bench builds the engine with 4 sets, 2 ways, degree 2, next-N of 2 and a 4-entry FIFO. The tiny FIFO lets a few instruction accesses fill it, so the drop-on-full path and the duplicate filter are both exercised. With only two ways, three PCs chosen to land in set 1 are enough to evict a trained entry, which makes the round-robin victim choice visible at the ports. A 48-byte stream against 64-byte blocks makes two prefetch targets fall in the same block, which exercises the filter between candidates generated in the same cycle.

// File: rtl/spf_pkg.sv
package spf_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_WINV  = 2'd2,
        KIND_OTHER = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        GEN_NONE   = 2'd0,
        GEN_STRIDE = 2'd1,
        GEN_SEQ    = 2'd2
    } gen_mode_e;

    function automatic int unsigned bits_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/spf_train.sv
module spf_train
    import spf_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PC_W     = 32,
    parameter int SETS     = 16,
    parameter int WAYS     = 4,
    parameter int PC_SHIFT = 2,
    parameter int CONF_TH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trn_en,
    input  logic [ADDR_W-1:0] trn_addr,
    input  logic [PC_W-1:0]   trn_pc,
    output logic              hit_issue,
    output logic [ADDR_W-1:0] hit_stride
);
    localparam int IDX_W = bits_for(SETS);
    localparam int WAY_W = bits_for(WAYS);

    logic              vld_q   [SETS][WAYS];
    logic [PC_W-1:0]   tag_q   [SETS][WAYS];
    logic [ADDR_W-1:0] last_q  [SETS][WAYS];
    logic [ADDR_W-1:0] strd_q  [SETS][WAYS];
    logic [1:0]        conf_q  [SETS][WAYS];
    logic              miss1_q [SETS][WAYS];
    logic [WAY_W-1:0]  rr_q    [SETS];

    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic [WAY_W-1:0]  hway;
    logic [ADDR_W-1:0] delta;
    logic              match;
    logic [1:0]        cur_conf;
    logic [1:0]        nxt_conf;
    logic [ADDR_W-1:0] nxt_strd;
    logic              nxt_miss1;

    assign idx = trn_pc[PC_SHIFT +: IDX_W];

    always_comb begin
        hit  = 1'b0;
        hway = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[idx][w] && tag_q[idx][w] == trn_pc) begin
                hit  = 1'b1;
                hway = WAY_W'(w);
            end
        end
    end

    assign delta    = trn_addr - last_q[idx][hway];
    assign match    = (delta == strd_q[idx][hway]);
    assign cur_conf = conf_q[idx][hway];

    always_comb begin
        nxt_conf  = cur_conf;
        nxt_strd  = strd_q[idx][hway];
        nxt_miss1 = 1'b0;
        if (match) begin
            nxt_conf = (cur_conf == 2'd3) ? 2'd3 : cur_conf + 2'd1;
        end else if (cur_conf == 2'd0) begin
            nxt_strd = delta;
        end else if (miss1_q[idx][hway]) begin
            nxt_conf = 2'd0;
            nxt_strd = delta;
        end else begin
            nxt_miss1 = 1'b1;
        end
    end

    assign hit_issue  = trn_en && hit && match && (int'(nxt_conf) >= CONF_TH);
    assign hit_stride = strd_q[idx][hway];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    vld_q[s][w]   <= 1'b0;
                    tag_q[s][w]   <= '0;
                    last_q[s][w]  <= '0;
                    strd_q[s][w]  <= '0;
                    conf_q[s][w]  <= '0;
                    miss1_q[s][w] <= 1'b0;
                end
            end
        end else if (trn_en) begin
            if (hit) begin
                last_q[idx][hway]  <= trn_addr;
                strd_q[idx][hway]  <= nxt_strd;
                conf_q[idx][hway]  <= nxt_conf;
                miss1_q[idx][hway] <= nxt_miss1;
            end else begin
                vld_q[idx][rr_q[idx]]   <= 1'b1;
                tag_q[idx][rr_q[idx]]   <= trn_pc;
                last_q[idx][rr_q[idx]]  <= trn_addr;
                strd_q[idx][rr_q[idx]]  <= '0;
                conf_q[idx][rr_q[idx]]  <= '0;
                miss1_q[idx][rr_q[idx]] <= 1'b0;
                rr_q[idx] <= (int'(rr_q[idx]) == WAYS - 1) ? '0 : rr_q[idx] + 1'b1;
            end
        end
    end

    AST_NO_ISSUE_ON_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        (trn_en && hit && !match) |-> !hit_issue); // R4

endmodule

// File: rtl/spf_addr_gen.sv
module spf_addr_gen
    import spf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NCAND     = 2,
    parameter int DEGREE    = 2,
    parameter int NEXT_N    = 2,
    parameter int BLK_BYTES = 64
) (
    input  gen_mode_e                     mode,
    input  logic [ADDR_W-1:0]             base_addr,
    input  logic [ADDR_W-1:0]             stride,
    output logic [NCAND-1:0]              cand_v,
    output logic [NCAND-1:0][ADDR_W-1:0]  cand_addr
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~(ADDR_W'(BLK_BYTES - 1));
    localparam logic [ADDR_W-1:0] BLK_STEP = ADDR_W'(BLK_BYTES);

    always_comb begin
        for (int k = 0; k < NCAND; k++) begin
            cand_v[k]    = 1'b0;
            cand_addr[k] = '0;
            if (mode == GEN_STRIDE && k < DEGREE) begin
                cand_v[k]    = 1'b1;
                cand_addr[k] = (base_addr + ADDR_W'(k + 1) * stride) & BLK_MASK;
            end else if (mode == GEN_SEQ && k < NEXT_N) begin
                cand_v[k]    = 1'b1;
                cand_addr[k] = (base_addr & BLK_MASK) + ADDR_W'(k + 1) * BLK_STEP;
            end
        end
    end

endmodule

// File: rtl/spf_queue.sv
module spf_queue
    import spf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PC_W   = 32,
    parameter int NCAND  = 2,
    parameter int QDEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NCAND-1:0]              cand_v,
    input  logic [NCAND-1:0][ADDR_W-1:0]  cand_addr,
    input  logic [PC_W-1:0]               cand_pc,
    output logic                          pf_valid,
    input  logic                          pf_ready,
    output logic [ADDR_W-1:0]             pf_addr,
    output logic [PC_W-1:0]               pf_pc
);
    localparam int PTR_W = bits_for(QDEPTH);
    localparam int CNT_W = $clog2(QDEPTH + 1);

    logic [ADDR_W-1:0] mem_a [QDEPTH];
    logic [PC_W-1:0]   mem_p [QDEPTH];
    logic              slot_v [QDEPTH];
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [NCAND-1:0]  take;
    logic [PTR_W-1:0]  wpos [NCAND];
    logic [CNT_W-1:0]  nacc;
    logic              pop;

    always_comb begin : accept
        logic [NCAND-1:0] tk;
        logic [CNT_W-1:0] n;
        logic             dup;
        tk = '0;
        n  = '0;
        for (int k = 0; k < NCAND; k++) begin
            dup = 1'b0;
            for (int i = 0; i < QDEPTH; i++) begin
                if (slot_v[i] && mem_a[i] == cand_addr[k]) dup = 1'b1;
            end
            for (int j = 0; j < k; j++) begin
                if (tk[j] && cand_addr[j] == cand_addr[k]) dup = 1'b1;
            end
            wpos[k] = tail_q + PTR_W'(n);
            if (cand_v[k] && !dup && (int'(cnt_q) + int'(n) < QDEPTH)) begin
                tk[k] = 1'b1;
                n     = n + 1'b1;
            end
        end
        take = tk;
        nacc = n;
    end

    assign pf_valid = (cnt_q != '0);
    assign pf_addr  = mem_a[head_q];
    assign pf_pc    = mem_p[head_q];
    assign pop      = pf_valid && pf_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < QDEPTH; i++) begin
                slot_v[i] <= 1'b0;
                mem_a[i]  <= '0;
                mem_p[i]  <= '0;
            end
        end else begin
            if (pop) begin
                slot_v[head_q] <= 1'b0;
                head_q <= (int'(head_q) == QDEPTH - 1) ? '0 : head_q + 1'b1;
            end
            for (int k = 0; k < NCAND; k++) begin
                if (take[k]) begin
                    mem_a[wpos[k]]  <= cand_addr[k];
                    mem_p[wpos[k]]  <= cand_pc;
                    slot_v[wpos[k]] <= 1'b1;
                end
            end
            tail_q <= tail_q + PTR_W'(nacc);
            cnt_q  <= cnt_q + nacc - CNT_W'(pop);
        end
    end

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= QDEPTH); // R10
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr) && $stable(pf_pc))); // R8

endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
    import spf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PC_W      = 32,
    parameter int SETS      = 16,
    parameter int WAYS      = 4,
    parameter int PC_SHIFT  = 2,
    parameter int DEGREE    = 2,
    parameter int NEXT_N    = 2,
    parameter int QDEPTH    = 8,
    parameter int BLK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic              acc_miss,
    input  logic              acc_instr,
    input  logic [1:0]        acc_kind,
    input  logic              cfg_miss_only,
    input  logic              cfg_data_only,
    input  logic              cfg_tag_pc,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [PC_W-1:0]   pf_pc
);
    localparam int NCAND = (DEGREE > NEXT_N) ? DEGREE : NEXT_N;

    logic                         acc_ok;
    logic                         trn_en;
    logic                         hit_issue;
    logic [ADDR_W-1:0]            hit_stride;
    gen_mode_e                    mode;
    logic [NCAND-1:0]             cand_v;
    logic [NCAND-1:0][ADDR_W-1:0] cand_addr;
    logic [PC_W-1:0]              cand_pc;

    assign acc_ok = acc_valid
                 && (acc_kind != KIND_WINV)
                 && (!cfg_miss_only || acc_miss)
                 && (!cfg_data_only || !acc_instr);
    assign trn_en  = acc_ok && !acc_instr;
    assign cand_pc = cfg_tag_pc ? acc_pc : '0;

    always_comb begin
        if (acc_ok && acc_instr) mode = GEN_SEQ;
        else if (hit_issue)      mode = GEN_STRIDE;
        else                     mode = GEN_NONE;
    end

    spf_train #(
        .ADDR_W(ADDR_W), .PC_W(PC_W), .SETS(SETS), .WAYS(WAYS),
        .PC_SHIFT(PC_SHIFT), .CONF_TH(2)
    ) u_train (
        .clk(clk), .rst(rst), .trn_en(trn_en), .trn_addr(acc_addr),
        .trn_pc(acc_pc), .hit_issue(hit_issue), .hit_stride(hit_stride)
    );

    spf_addr_gen #(
        .ADDR_W(ADDR_W), .NCAND(NCAND), .DEGREE(DEGREE),
        .NEXT_N(NEXT_N), .BLK_BYTES(BLK_BYTES)
    ) u_gen (
        .mode(mode), .base_addr(acc_addr), .stride(hit_stride),
        .cand_v(cand_v), .cand_addr(cand_addr)
    );

    spf_queue #(
        .ADDR_W(ADDR_W), .PC_W(PC_W), .NCAND(NCAND), .QDEPTH(QDEPTH)
    ) u_queue (
        .clk(clk), .rst(rst), .cand_v(cand_v), .cand_addr(cand_addr),
        .cand_pc(cand_pc), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_addr(pf_addr), .pf_pc(pf_pc)
    );

    AST_WINV_FILTERED: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_kind == KIND_WINV) |-> (!trn_en && cand_v == '0)); // R7
    AST_INSTR_NO_TRAIN: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_instr) |-> !trn_en); // R5

endmodule

// File: tb/test_stride_prefetcher.sv
`timescale 1ns/1ps
module test_stride_prefetcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [31:0] acc_pc = '0;
    logic        acc_miss = 1'b1;
    logic        acc_instr = 1'b0;
    logic [1:0]  acc_kind = 2'b00;
    logic        cfg_miss_only = 1'b0;
    logic        cfg_data_only = 1'b0;
    logic        cfg_tag_pc = 1'b1;
    logic        pf_valid;
    logic        pf_ready = 1'b0;
    logic [31:0] pf_addr;
    logic [31:0] pf_pc;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    stride_prefetcher #(
        .ADDR_W(32), .PC_W(32), .SETS(4), .WAYS(2), .PC_SHIFT(2),
        .DEGREE(2), .NEXT_N(2), .QDEPTH(4), .BLK_BYTES(64)
    ) i_stride_prefetcher (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_pc(acc_pc), .acc_miss(acc_miss), .acc_instr(acc_instr),
        .acc_kind(acc_kind), .cfg_miss_only(cfg_miss_only),
        .cfg_data_only(cfg_data_only), .cfg_tag_pc(cfg_tag_pc),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_pc(pf_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input logic [31:0] pc,
                          input bit miss, input bit instr, input logic [1:0] kind);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_pc = pc;
        acc_miss = miss; acc_instr = instr; acc_kind = kind;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic data(input logic [31:0] a, input logic [31:0] pc);
        access(a, pc, 1'b1, 1'b0, 2'b00);
    endtask

    task automatic instr(input logic [31:0] a);
        access(a, 32'h0, 1'b1, 1'b1, 2'b00);
    endtask

    task automatic pop_expect(input string req, input logic [31:0] ea, input logic [31:0] epc);
        check({req, " valid"}, {31'd0, pf_valid}, 32'd1);
        check({req, " addr"}, pf_addr, ea);
        check({req, " pc"}, pf_pc, epc);
        pf_ready = 1'b1;
        @(negedge clk);
        pf_ready = 1'b0;
    endtask

    task automatic expect_empty(input string req);
        check({req, " empty"}, {31'd0, pf_valid}, 32'd0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 in reset", {31'd0, pf_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {31'd0, pf_valid}, 32'd0);
    endtask

    task automatic t_byte_stride;
        data(32'h1000, 32'h100); expect_empty("R3 first");
        data(32'h1030, 32'h100); expect_empty("R3 second");
        data(32'h1060, 32'h100); expect_empty("R3 third");
        data(32'h1090, 32'h100);
        repeat (3) @(negedge clk);
        pop_expect("R2 R9 stall hold", 32'h10C0, 32'h100);
        expect_empty("R9 same-batch dup");
        data(32'h10C0, 32'h100);
        pop_expect("R8 order 1", 32'h10C0, 32'h100);
        pop_expect("R8 order 2", 32'h1100, 32'h100);
        expect_empty("R8 drained");
    endtask

    task automatic t_mispredict;
        data(32'h5000, 32'h100); expect_empty("R4 single miss");
        data(32'h5030, 32'h100);
        pop_expect("R4 kept stride 1", 32'h5040, 32'h100);
        pop_expect("R4 kept stride 2", 32'h5080, 32'h100);
        data(32'h9000, 32'h100);
        data(32'hA000, 32'h100); expect_empty("R4 second miss");
        data(32'hB000, 32'h100); expect_empty("R4 confidence cleared");
        data(32'hC000, 32'h100);
        pop_expect("R4 retrained 1", 32'hD000, 32'h100);
        pop_expect("R4 retrained 2", 32'hE000, 32'h100);
    endtask

    task automatic t_instr;
        cfg_tag_pc = 1'b0;
        access(32'h2010, 32'h100, 1'b1, 1'b1, 2'b00);
        pop_expect("R5 R11 next block 1", 32'h2040, 32'h0);
        pop_expect("R5 R11 next block 2", 32'h2080, 32'h0);
        cfg_tag_pc = 1'b1;
        data(32'hD000, 32'h100);
        pop_expect("R5 no training 1", 32'hE000, 32'h100);
        pop_expect("R5 no training 2", 32'hF000, 32'h100);
    endtask

    task automatic t_winv;
        access(32'hE000, 32'h100, 1'b1, 1'b0, 2'b10);
        expect_empty("R7 winv ignored");
        data(32'hE000, 32'h100);
        pop_expect("R7 state untouched 1", 32'hF000, 32'h100);
        pop_expect("R7 state untouched 2", 32'h10000, 32'h100);
    endtask

    task automatic t_config;
        cfg_miss_only = 1'b1;
        access(32'hF000, 32'h100, 1'b0, 1'b0, 2'b00);
        expect_empty("R6 hit ignored");
        data(32'hF000, 32'h100);
        pop_expect("R6 miss used 1", 32'h10000, 32'h100);
        pop_expect("R6 miss used 2", 32'h11000, 32'h100);
        access(32'h2010, 32'h0, 1'b0, 1'b1, 2'b00);
        expect_empty("R6 instr hit ignored");
        cfg_miss_only = 1'b0;
        cfg_data_only = 1'b1;
        instr(32'h2010);
        expect_empty("R6 data only");
        cfg_data_only = 1'b0;
    endtask

    task automatic t_full;
        cfg_tag_pc = 1'b0;
        instr(32'h30000);
        instr(32'h30040);
        instr(32'h31000);
        pop_expect("R10 R9 q1", 32'h30040, 32'h0);
        pop_expect("R10 R9 q2", 32'h30080, 32'h0);
        pop_expect("R10 R9 q3", 32'h300C0, 32'h0);
        pop_expect("R10 q4", 32'h31040, 32'h0);
        expect_empty("R10 overflow dropped");
        cfg_tag_pc = 1'b1;
    endtask

    task automatic t_replace;
        data(32'h40000, 32'h204);
        data(32'h40100, 32'h204);
        data(32'h40200, 32'h204);
        data(32'h40300, 32'h204);
        pop_expect("R12 trained 1", 32'h40400, 32'h204);
        pop_expect("R12 trained 2", 32'h40500, 32'h204);
        data(32'h50000, 32'h214);
        data(32'h60000, 32'h224);
        expect_empty("R12 allocations");
        data(32'h40400, 32'h204); expect_empty("R12 evicted 1");
        data(32'h40500, 32'h204); expect_empty("R12 evicted 2");
    endtask

    initial begin
        t_reset();
        t_byte_stride();
        t_mispredict();
        t_instr();
        t_winv();
        t_config();
        t_full();
        t_replace();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule